// File: doc/BRIEF.md
# Firmware Hub Write-Cycle Target

This block is the target side of a 4-bit multiplexed firmware-hub bus. It samples an active-low frame strobe and a shared nibble bus on every rising clock edge. From that stream it recognises the opening of a write frame, compares the chip-select nibble with a strap input, and shifts in a 28-bit address. It then decodes a transfer-size nibble and collects one, two or four data bytes. When the frame completes, the block takes over the shared bus for three cycles and answers with the fixed handshake.

The host side drives `nib_in` and `frame_n`. The block drives the returned nibbles on `nib_out` and enables them with `nib_oe`; a pad ring or wrapper outside the block combines these into the shared bus. In the sync cycle the block issues a one-cycle `wr_req` pulse. With it come the address, the byte count, the data and a flag that says whether the write targets the memory array or the register space. Downstream logic acts on that pulse.

Top module: `fwh_write_target`

## Requirements
- R1: A frame opens only at a rising edge where `frame_n` is 0 and `nib_in` is 4'b1110. The value 1110 seen with `frame_n` high opens nothing. Any other nibble seen with `frame_n` low opens nothing.
- R2: The nibble after the opening one must equal `strap_id`. If it differs, the rest of the frame produces no `wr_req` and `nib_oe` never rises.
- R3: The next seven nibbles form the 28-bit address, most significant nibble first.
- R4: When address bit 22 is 1, `wr_is_mem` is 1 and `wr_addr` bits 19 to 21 and 23 to 27 read as 0. When bit 22 is 0, `wr_is_mem` is 0 and all 28 bits are passed through.
- R5: The size nibble 4'b0000 selects 1 byte, 4'b0001 selects 2 bytes and 4'b0010 selects 4 bytes. These take 2, 4 and 8 data nibbles, and `wr_bytes` carries the byte count in binary.
- R6: Each byte arrives low nibble first, and bytes arrive in ascending order. Byte k appears at `wr_data[8k+7:8k]`, and bytes not transferred read as 0.
- R7: After the last data nibble, the host's turnaround cycle is followed by one cycle in which `nib_oe` is 1 and `nib_out` is 4'b1111.
- R8: The next cycle is the sync cycle. In it `nib_oe` is 1 and `nib_out` is 4'b0000, and `wr_req` is 1 for this cycle only, with all write fields valid.
- R9: After sync comes one cycle with `nib_oe` 1 and `nib_out` 4'b1111, and then `nib_oe` returns to 0. `nib_oe` is 1 for exactly these three cycles of an accepted frame and is 0 at all other times.
- R10: A size nibble other than 0000, 0001 or 0010 ends the frame. No `wr_req` follows and `nib_oe` stays 0.
- R11: If `frame_n` is sampled low while a frame is in progress, that frame is dropped. If the nibble on that edge is 1110, a new frame starts with its ID field.
- R12: An asynchronous active-low reset returns the block to idle, with `nib_oe` and `wr_req` at 0, including when it hits in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | Frame strobe from the host, active low |
| nib_in | input | 4 | Nibble sampled from the shared bus |
| strap_id | input | 4 | Chip-select strap value |
| nib_out | output | 4 | Nibble driven back to the bus |
| nib_oe | output | 1 | Output enable for `nib_out` |
| wr_req | output | 1 | One-cycle write request in the sync cycle |
| wr_addr | output | 28 | Assembled address (masked in memory space) |
| wr_bytes | output | 3 | Number of bytes transferred (1, 2 or 4) |
| wr_data | output | 32 | Data bytes, byte 0 in the low bits |
| wr_is_mem | output | 1 | 1 for memory array, 0 for register space |

## Verification
The bench builds the block with its defaults: seven address nibbles, up to four bytes, bit 22 as the space selector and nineteen low bits kept in memory space. These values put every legal size code within reach, as well as the first illegal codes just above them. Both address spaces can be exercised, and the masking of every high address nibble can be seen at the ports. Because the address spans exactly seven nibbles, an abort is easy to place at any chosen address position.

// File: rtl/fwh_pkg.sv
package fwh_pkg;

  localparam logic [3:0] START_NIB = 4'b1110;
  localparam logic [3:0] SYNC_NIB  = 4'b0000;
  localparam logic [3:0] TAR_NIB   = 4'b1111;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_ID,
    PH_ADDR,
    PH_SIZE,
    PH_DATA,
    PH_HTAR,
    PH_OWN,
    PH_SYNC,
    PH_TTAR
  } phase_t;

  // Legal size codes are 0 .. n_codes-1 (each doubles the byte count)
  function automatic logic size_code_ok(input logic [3:0] code, input int n_codes);
    return int'(code) < n_codes;
  endfunction

  function automatic int size_code_bytes(input logic [3:0] code);
    return 1 << code;
  endfunction

  // Two nibbles per byte
  function automatic int data_nibbles(input int bytes);
    return 2 * bytes;
  endfunction

  // In memory space only the low bits and the space selector survive
  function automatic logic bit_kept_in_mem(input int idx, input int keep_lsbs, input int sel_bit);
    return (idx < keep_lsbs) || (idx == sel_bit);
  endfunction

endpackage

// File: rtl/fwh_phase_fsm.sv
module fwh_phase_fsm
  import fwh_pkg::*;
#(
  parameter int ADDR_NIBS = 7,
  parameter int MAX_BYTES = 4,
  parameter int CNT_W     = 4,
  parameter int BYTES_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_n,
  input  logic [3:0]         nib_in,
  input  logic [3:0]         strap_id,
  output phase_t             phase_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [BYTES_W-1:0] bytes_o,
  output logic               ev_start_o,
  output logic               ev_id_miss_o,
  output logic               ev_bad_size_o,
  output logic               ev_abort_o
);

  localparam int SIZE_CODES = $clog2(MAX_BYTES) + 1;

  phase_t             phase_q, phase_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [BYTES_W-1:0] bytes_q, bytes_d;
  logic [CNT_W-1:0]   data_last;
  logic               ev_start, ev_id_miss, ev_bad_size, ev_abort;

  assign data_last = CNT_W'(data_nibbles(int'(bytes_q)) - 1);

  always_comb begin
    phase_d     = phase_q;
    cnt_d       = cnt_q;
    bytes_d     = bytes_q;
    ev_id_miss  = 1'b0;
    ev_bad_size = 1'b0;
    ev_start    = !frame_n && (nib_in == START_NIB);
    ev_abort    = !frame_n && (phase_q != PH_IDLE);
    if (!frame_n) begin
      // strobe low: (re)start detection in any phase
      phase_d = ev_start ? PH_ID : PH_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: phase_d = PH_IDLE;
        PH_ID: begin
          if (nib_in == strap_id) begin
            phase_d = PH_ADDR;
            cnt_d   = '0;
          end else begin
            ev_id_miss = 1'b1;
            phase_d    = PH_IDLE;
          end
        end
        PH_ADDR: begin
          if (cnt_q == CNT_W'(ADDR_NIBS - 1)) begin
            phase_d = PH_SIZE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_SIZE: begin
          if (size_code_ok(nib_in, SIZE_CODES)) begin
            phase_d = PH_DATA;
            bytes_d = BYTES_W'(size_code_bytes(nib_in));
            cnt_d   = '0;
          end else begin
            ev_bad_size = 1'b1;
            phase_d     = PH_IDLE;
          end
        end
        PH_DATA: begin
          if (cnt_q == data_last) begin
            phase_d = PH_HTAR;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_HTAR: phase_d = PH_OWN;
        PH_OWN:  phase_d = PH_SYNC;
        PH_SYNC: phase_d = PH_TTAR;
        PH_TTAR: phase_d = PH_IDLE;
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      bytes_q <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      bytes_q <= bytes_d;
    end
  end

  assign phase_o       = phase_q;
  assign cnt_o         = cnt_q;
  assign bytes_o       = bytes_q;
  assign ev_start_o    = ev_start;
  assign ev_id_miss_o  = ev_id_miss;
  assign ev_bad_size_o = ev_bad_size;
  assign ev_abort_o    = ev_abort;

endmodule

// File: rtl/fwh_addr_capture.sv
module fwh_addr_capture
  import fwh_pkg::*;
#(
  parameter int ADDR_NIBS     = 7,
  parameter int MEM_BIT       = 22,
  parameter int MEM_KEEP_LSBS = 19,
  parameter int ADDR_W        = 4 * ADDR_NIBS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic [3:0]        nib_in,
  output logic [ADDR_W-1:0] addr_o,
  output logic              is_mem_o
);

  logic [ADDR_W-1:0] raw_q;

  // most significant nibble arrives first: shift left, new nibble at bottom
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        raw_q <= '0;
    else if (clr)      raw_q <= '0;
    else if (shift_en) raw_q <= {raw_q[ADDR_W-5:0], nib_in};
  end

  assign is_mem_o = raw_q[MEM_BIT];

  for (genvar b = 0; b < ADDR_W; b++) begin : g_mask
    if (bit_kept_in_mem(b, MEM_KEEP_LSBS, MEM_BIT)) begin : g_keep
      assign addr_o[b] = raw_q[b];
    end else begin : g_dc
      assign addr_o[b] = raw_q[b] & ~raw_q[MEM_BIT];
    end
  end

endmodule

// File: rtl/fwh_data_capture.sv
module fwh_data_capture #(
  parameter int MAX_BYTES = 4,
  parameter int CNT_W     = 4,
  parameter int DATA_W    = 8 * MAX_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  idx,
  input  logic [3:0]        nib_in,
  output logic [DATA_W-1:0] data_o
);

  localparam int NIBS = 2 * MAX_BYTES;

  // nibble k of the data phase lands at bits 4k+3:4k (low nibble first,
  // bytes ascending), so each slot has a fixed position
  for (genvar k = 0; k < NIBS; k++) begin : g_slot
    logic [3:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            slot_q <= '0;
      else if (clr)                          slot_q <= '0;
      else if (wr_en && idx == CNT_W'(k))    slot_q <= nib_in;
    end
    assign data_o[4*k +: 4] = slot_q;
  end

endmodule

// File: rtl/fwh_bus_drive.sv
module fwh_bus_drive
  import fwh_pkg::*;
(
  input  phase_t     phase,
  output logic [3:0] nib_out,
  output logic       nib_oe,
  output logic       wr_req
);

  always_comb begin
    nib_oe  = 1'b0;
    nib_out = TAR_NIB;
    wr_req  = 1'b0;
    unique case (phase)
      PH_OWN:  nib_oe = 1'b1;
      PH_SYNC: begin
        nib_oe  = 1'b1;
        nib_out = SYNC_NIB;
        wr_req  = 1'b1;
      end
      PH_TTAR: nib_oe = 1'b1;
      default: nib_oe = 1'b0;
    endcase
  end

endmodule

// File: rtl/fwh_write_target.sv
module fwh_write_target
  import fwh_pkg::*;
#(
  parameter int ADDR_NIBS     = 7,
  parameter int MAX_BYTES     = 4,
  parameter int MEM_BIT       = 22,
  parameter int MEM_KEEP_LSBS = 19
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             frame_n,
  input  logic [3:0]                       nib_in,
  input  logic [3:0]                       strap_id,
  output logic [3:0]                       nib_out,
  output logic                             nib_oe,
  output logic                             wr_req,
  output logic [4*ADDR_NIBS-1:0]           wr_addr,
  output logic [$clog2(MAX_BYTES+1)-1:0]   wr_bytes,
  output logic [8*MAX_BYTES-1:0]           wr_data,
  output logic                             wr_is_mem
);

  localparam int ADDR_W  = 4 * ADDR_NIBS;
  localparam int DATA_W  = 8 * MAX_BYTES;
  localparam int BYTES_W = $clog2(MAX_BYTES + 1);
  localparam int CNT_MAX = (ADDR_NIBS > 2 * MAX_BYTES) ? ADDR_NIBS : 2 * MAX_BYTES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  // named internal events, visible to the bound checker
  phase_t             phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               ev_start;
  logic               ev_id_miss;
  logic               ev_bad_size;
  logic               ev_abort;
  logic               addr_shift;
  logic               data_load;

  fwh_phase_fsm #(
    .ADDR_NIBS(ADDR_NIBS),
    .MAX_BYTES(MAX_BYTES),
    .CNT_W    (CNT_W),
    .BYTES_W  (BYTES_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_n      (frame_n),
    .nib_in       (nib_in),
    .strap_id     (strap_id),
    .phase_o      (phase_q),
    .cnt_o        (cnt_q),
    .bytes_o      (wr_bytes),
    .ev_start_o   (ev_start),
    .ev_id_miss_o (ev_id_miss),
    .ev_bad_size_o(ev_bad_size),
    .ev_abort_o   (ev_abort)
  );

  assign addr_shift = frame_n && (phase_q == PH_ADDR);
  assign data_load  = frame_n && (phase_q == PH_DATA);

  fwh_addr_capture #(
    .ADDR_NIBS    (ADDR_NIBS),
    .MEM_BIT      (MEM_BIT),
    .MEM_KEEP_LSBS(MEM_KEEP_LSBS),
    .ADDR_W       (ADDR_W)
  ) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ev_start),
    .shift_en(addr_shift),
    .nib_in  (nib_in),
    .addr_o  (wr_addr),
    .is_mem_o(wr_is_mem)
  );

  fwh_data_capture #(
    .MAX_BYTES(MAX_BYTES),
    .CNT_W    (CNT_W),
    .DATA_W   (DATA_W)
  ) u_data (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ev_start),
    .wr_en (data_load),
    .idx   (cnt_q),
    .nib_in(nib_in),
    .data_o(wr_data)
  );

  fwh_bus_drive u_drive (
    .phase  (phase_q),
    .nib_out(nib_out),
    .nib_oe (nib_oe),
    .wr_req (wr_req)
  );

endmodule

// File: rtl/fwh_write_chk.sv
module fwh_write_chk
  import fwh_pkg::*;
#(
  parameter int ADDR_NIBS     = 7,
  parameter int MAX_BYTES     = 4,
  parameter int MEM_BIT       = 22,
  parameter int MEM_KEEP_LSBS = 19
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           frame_n,
  input logic [3:0]                     nib_out,
  input logic                           nib_oe,
  input logic                           wr_req,
  input logic [4*ADDR_NIBS-1:0]         wr_addr,
  input logic [$clog2(MAX_BYTES+1)-1:0] wr_bytes,
  input logic                           wr_is_mem,
  input phase_t                         phase_q,
  input logic                           ev_id_miss,
  input logic                           ev_bad_size,
  input logic                           ev_abort
);

  localparam int ADDR_W = 4 * ADDR_NIBS;

  function automatic logic [ADDR_W-1:0] dc_mask();
    logic [ADDR_W-1:0] m;
    for (int i = 0; i < ADDR_W; i++) m[i] = !bit_kept_in_mem(i, MEM_KEEP_LSBS, MEM_BIT);
    return m;
  endfunction

  localparam logic [ADDR_W-1:0] DC_MASK = dc_mask();

  logic [3:0] oe_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      oe_run <= '0;
    else if (!nib_oe) oe_run <= '0;
    else if (oe_run != 4'hF) oe_run <= oe_run + 1'b1;
  end

  assert_sync_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (nib_oe && nib_out == SYNC_NIB));

  assert_tar_after_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && frame_n) |=> (nib_oe && nib_out == TAR_NIB && !wr_req));

  assert_oe_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_run <= 4'd3);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE) |-> (!nib_oe && !wr_req));

  assert_own_leads_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(nib_oe) && frame_n) |=> wr_req);

  assert_own_drives_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nib_oe) |-> nib_out == TAR_NIB);

  assert_id_miss_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_id_miss |=> (!nib_oe && !wr_req));

  assert_bad_size_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad_size |=> (!nib_oe && !wr_req));

  assert_abort_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (!nib_oe && !wr_req));

  assert_bytes_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> ($onehot(wr_bytes) && int'(wr_bytes) <= MAX_BYTES));

  assert_mem_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_is_mem) |-> ((wr_addr & DC_MASK) == '0));

endmodule

bind fwh_write_target fwh_write_chk #(
  .ADDR_NIBS    (ADDR_NIBS),
  .MAX_BYTES    (MAX_BYTES),
  .MEM_BIT      (MEM_BIT),
  .MEM_KEEP_LSBS(MEM_KEEP_LSBS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_n    (frame_n),
  .nib_out    (nib_out),
  .nib_oe     (nib_oe),
  .wr_req     (wr_req),
  .wr_addr    (wr_addr),
  .wr_bytes   (wr_bytes),
  .wr_is_mem  (wr_is_mem),
  .phase_q    (phase_q),
  .ev_id_miss (ev_id_miss),
  .ev_bad_size(ev_bad_size),
  .ev_abort   (ev_abort)
);

// File: tb/sim_fwh_write_target.sv
`timescale 1ns/1ps
module sim_fwh_write_target;

  localparam int HALF = 10;  // 50 MHz

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic [3:0]  nib_in = 4'hF;
  logic [3:0]  strap_id = 4'h5;
  logic [3:0]  nib_out;
  logic        nib_oe;
  logic        wr_req;
  logic [27:0] wr_addr;
  logic [2:0]  wr_bytes;
  logic [31:0] wr_data;
  logic        wr_is_mem;

  int checks = 0;
  int failures = 0;
  int oe_cnt = 0;
  int req_cnt = 0;

  always #HALF clk = ~clk;

  fwh_write_target u0 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .nib_in(nib_in),
    .strap_id(strap_id), .nib_out(nib_out), .nib_oe(nib_oe),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_bytes(wr_bytes),
    .wr_data(wr_data), .wr_is_mem(wr_is_mem)
  );

  always @(negedge clk) begin
    if (nib_oe) oe_cnt++;
    if (wr_req) req_cnt++;
  end

  // {id, addr, size, data, resp, mem, bytes, expected addr}
  localparam int NV = 7;
  localparam logic [100:0] VEC [NV] = '{
    {4'h5, 28'hFC7A5B3, 4'h0, 32'h0000003C, 1'b1, 1'b1, 3'd1, 28'h047A5B3},
    {4'h5, 28'h1234567, 4'h1, 32'h0000BEEF, 1'b1, 1'b0, 3'd2, 28'h1234567},
    {4'h5, 28'h0400000, 4'h2, 32'hDEADBEEF, 1'b1, 1'b1, 3'd4, 28'h0400000},
    {4'h6, 28'h1234567, 4'h2, 32'h11223344, 1'b0, 1'b0, 3'd0, 28'h0000000},
    {4'h5, 28'hFB9C0DE, 4'h2, 32'h01234567, 1'b1, 1'b0, 3'd4, 28'hFB9C0DE},
    {4'h5, 28'h1234567, 4'h3, 32'h000000AA, 1'b0, 1'b0, 3'd0, 28'h0000000},
    {4'h5, 28'h1234567, 4'hF, 32'h000000AA, 1'b0, 1'b0, 3'd0, 28'h0000000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic fr, input logic [3:0] n);
    @(negedge clk);
    frame_n = fr;
    nib_in  = n;
  endtask

  task automatic send_frame(input logic [3:0] id, input logic [27:0] addr,
                            input logic [3:0] size, input logic [31:0] data, input int nd);
    drive(1'b0, 4'hE);
    drive(1'b1, id);
    for (int i = 6; i >= 0; i--) drive(1'b1, addr[4*i +: 4]);
    drive(1'b1, size);
    for (int j = 0; j < nd; j++) drive(1'b1, data[4*j +: 4]);
    drive(1'b1, 4'hF);  // host turnaround; bus then released (pulled high)
  endtask

  task automatic expect_ack(input logic [27:0] eaddr, input logic [2:0] ebytes,
                            input logic [31:0] edata, input logic emem);
    @(negedge clk);
    chk("R7 own oe", nib_oe, 1);
    chk("R7 own nibble", nib_out, 4'hF);
    chk("R8 no early req", wr_req, 0);
    @(negedge clk);
    chk("R8 sync oe", nib_oe, 1);
    chk("R8 sync nibble", nib_out, 4'h0);
    chk("R8 req pulse", wr_req, 1);
    chk("R3 R4 addr", wr_addr, eaddr);
    chk("R4 space flag", wr_is_mem, emem);
    chk("R5 bytes", wr_bytes, ebytes);
    chk("R6 data", wr_data, edata);
    @(negedge clk);
    chk("R9 tar oe", nib_oe, 1);
    chk("R9 tar nibble", nib_out, 4'hF);
    chk("R8 req single", wr_req, 0);
    @(negedge clk);
    chk("R9 release", nib_oe, 0);
    #1;
    chk("R9 oe cycles", oe_cnt, 3);
    chk("R8 req count", req_cnt, 1);
  endtask

  task automatic expect_silent(input string req);
    repeat (4) @(negedge clk);
    #1;
    chk({req, " no drive"}, oe_cnt, 0);
    chk({req, " no req"}, req_cnt, 0);
  endtask

  task automatic clear_counts();
    @(posedge clk);
    #1;
    oe_cnt  = 0;
    req_cnt = 0;
  endtask

  initial begin
    #(HALF * 2 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // reset state (R12)
    repeat (3) @(negedge clk);
    chk("R12 reset oe", nib_oe, 0);
    chk("R12 reset req", wr_req, 0);
    rst_n = 1'b1;

    // vector table walk: back-to-back frames
    for (int v = 0; v < NV; v++) begin
      logic [100:0] e;
      int nd;
      e = VEC[v];
      nd = (e[68:65] <= 4'h2) ? (2 << e[68:65]) : 2;
      clear_counts();
      send_frame(e[100:97], e[96:69], e[68:65], e[64:33], nd);
      if (e[32]) expect_ack(e[27:0], e[30:28], e[64:33], e[31]);
      else if (e[100:97] != strap_id) expect_silent("R2");
      else expect_silent("R10");
    end

    // R1: 1110 with strobe high, and another nibble with strobe low
    clear_counts();
    drive(1'b1, 4'hE);
    drive(1'b1, 4'h5);
    for (int i = 0; i < 10; i++) drive(1'b1, 4'h0);
    drive(1'b1, 4'hF);
    expect_silent("R1 high strobe");
    clear_counts();
    drive(1'b0, 4'h0);
    drive(1'b1, 4'h5);
    for (int i = 0; i < 10; i++) drive(1'b1, 4'h0);
    drive(1'b1, 4'hF);
    expect_silent("R1 wrong nibble");

    // R11: restart mid address, new frame must be taken in full
    clear_counts();
    drive(1'b0, 4'hE);
    drive(1'b1, 4'h5);
    drive(1'b1, 4'hA);
    drive(1'b1, 4'hB);
    drive(1'b1, 4'hC);
    send_frame(4'h5, 28'h0654321, 4'h1, 32'h00007788, 4);
    expect_ack(28'h0454321, 3'd2, 32'h00007788, 1'b1);

    // R11: strobe low with a non-start nibble drops the frame
    clear_counts();
    drive(1'b0, 4'hE);
    drive(1'b1, 4'h5);
    drive(1'b1, 4'h1);
    drive(1'b1, 4'h2);
    drive(1'b0, 4'h3);
    for (int i = 0; i < 8; i++) drive(1'b1, 4'h0);
    drive(1'b1, 4'hF);
    expect_silent("R11 abort");

    // R2: changed strap, matching and stale ID
    strap_id = 4'hA;
    clear_counts();
    send_frame(4'hA, 28'h1234567, 4'h0, 32'h0000005A, 2);
    expect_ack(28'h1234567, 3'd1, 32'h0000005A, 1'b0);
    clear_counts();
    send_frame(4'h5, 28'h1234567, 4'h0, 32'h0000005A, 2);
    expect_silent("R2 stale id");

    // R12: reset in the middle of the data phase
    clear_counts();
    drive(1'b0, 4'hE);
    drive(1'b1, 4'hA);
    for (int i = 0; i < 7; i++) drive(1'b1, 4'h1);
    drive(1'b1, 4'h2);
    for (int i = 0; i < 3; i++) drive(1'b1, 4'h7);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R12 mid-frame reset oe", nib_oe, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) drive(1'b1, 4'h7);
    drive(1'b1, 4'hF);
    expect_silent("R12 after reset");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule